// File: doc/BRIEF.md
# Banked UART Register Decoder

This block is the configuration register file of one UART channel. A processor reaches it through a 3-bit address, an 8-bit write bus with a write strobe, and an 8-bit read bus. Eight addresses are too few for every register the channel needs, so several banks share them. Which bank an address reaches depends on two registers the processor has already written: the line control register and the extra-feature control register. The line control register sits at address 3 and the extra-feature control register at address 5. Both answer in every bank, so software can always switch banks or return to the normal one.

Every stored register is driven straight out to the serial datapath as a plain output. Read data is registered. The value appears on the read bus one clock after the address is presented, and it reflects register contents from before that edge. The serial engine, the FIFOs and interrupt generation are outside this block.

Bank selection uses bits 2:1 of the extra-feature control register, called the bank field below. Field value 01 selects extra set one and 10 selects extra set two. These take priority over everything else. Value 11 leaves only addresses 3 and 5 reachable. With the field at 00, a line control value equal to the enhanced key (0xBF) opens the enhanced bank. Otherwise, line control bit 7 set opens the divisor bank. Otherwise, extra-feature bit 0 set opens the special bank. If none of these apply, the normal bank is in use.

Top module: `uart_bank_regs`

## Requirements
- R1: After reset every register output and the read bus are 0x00.
- R2: In the normal bank (bank field 00, line control bit 7 clear, extra-feature bit 0 clear), address 1 is interrupt enable, 2 is FIFO control, 4 is modem control and 7 is scratch. A read presented in one cycle shows the value on the read bus after the next clock edge.
- R3: Address 3 (line control) and address 5 (extra-feature control) can be written and read in every bank.
- R4: In the divisor bank (bank field 00, line control bit 7 set, line control not 0xBF), address 0 is the divisor low byte and address 1 is the high byte.
- R5: The enhanced bank is reached only with line control exactly 0xBF and bank field 00. In it, address 2 is the enhanced feature register, addresses 0/1 are the Xon low/high bytes, and addresses 6/7 are the Xoff low/high bytes. In any other state these registers hold their values.
- R6: With bank field 01 (extra-feature value 0x02), address 2 is the transmit level, 4 the receive level, 6 the flow-control high count and 7 the flow-control low count.
- R7: With bank field 10 (extra-feature value 0x04), address 2 is the clock prescaler, 4 the RS-485 turnaround time, 6 advanced control two and 7 advanced control one.
- R8: The clock prescaler stores only its low 4 bits. Its upper 4 bits read 0 and ignore writes.
- R9: Interrupt-enable bits 3:0 always take a write. Bits 7:4 take a write only while bit 4 of the enhanced feature register is 1, and otherwise hold.
- R10: In the special bank (bank field 00, line control bit 7 clear, extra-feature bit 0 set), address 4 is special register zero and 7 is special register one. The normal-bank registers are not reachable there.
- R11: An address with no register in the current bank reads 0x00, and a write to it changes no register. With bank field 11 only addresses 3 and 5 are mapped.
- R12: When a write and a read fall in the same cycle, the read returns the contents from before the write. A bank change takes effect from the cycle after the control-register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe for the addressed register |
| rdata | output | 8 | Registered read data |
| ier | output | 8 | Interrupt enable |
| fcr | output | 8 | FIFO control |
| mcr | output | 8 | Modem control |
| scratch | output | 8 | Scratch register |
| lcr | output | 8 | Line control |
| efcr | output | 8 | Extra-feature control (bank field in bits 2:1) |
| divisor | output | 16 | Baud divisor {high, low} |
| efr | output | 8 | Enhanced feature register |
| xon | output | 16 | Xon character pair {high, low} |
| xoff | output | 16 | Xoff character pair {high, low} |
| tx_level | output | 8 | Transmit interrupt level |
| rx_level | output | 8 | Receive interrupt level |
| flow_hi | output | 8 | Flow-control high count |
| flow_lo | output | 8 | Flow-control low count |
| prescale | output | 8 | Clock prescaler (bits 7:4 always 0) |
| turnaround | output | 8 | RS-485 turnaround time |
| afc2 | output | 8 | Advanced control two |
| afc1 | output | 8 | Advanced control one |
| spec0 | output | 8 | Special register zero |
| spec1 | output | 8 | Special register one |

## Verification
Two operations can fall in the same cycle: a register write and a registered read. This includes a write to line control or extra-feature control that changes the bank while the read is decoded. The bench provokes this by writing the scratch register while reading it, and by writing line control while reading address 3. Each read must return the pre-write value. The next read of address 0 must then land in the divisor bank opened by that write.

// File: rtl/uart_bank_pkg.sv
package uart_bank_pkg;

  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    BK_NORMAL,
    BK_DIVISOR,
    BK_ENHANCED,
    BK_SPECIAL,
    BK_EXTRA1,
    BK_EXTRA2,
    BK_NONE
  } bank_e;

  typedef enum logic [4:0] {
    RG_IER, RG_FCR, RG_MCR, RG_SCR,
    RG_DLL, RG_DLH,
    RG_EFR, RG_XON_LO, RG_XON_HI, RG_XOFF_LO, RG_XOFF_HI,
    RG_LCR, RG_EFCR,
    RG_TXLVL, RG_RXLVL, RG_FLOWH, RG_FLOWL,
    RG_PRESC, RG_RS485T, RG_AFC2, RG_AFC1,
    RG_SPC0, RG_SPC1
  } reg_e;

  localparam int NREG = 23;

  localparam logic [ADDR_W-1:0] A_LCR  = 3'd3;
  localparam logic [ADDR_W-1:0] A_EFCR = 3'd5;

  // enhanced-feature bit that unlocks the upper interrupt-enable bits
  localparam int EFR_UNLOCK_BIT = 4;

endpackage

// File: rtl/uart_bank_select.sv
module uart_bank_select
  import uart_bank_pkg::*;
#(
  parameter logic [DATA_W-1:0] ENH_KEY = 8'hBF
) (
  input  logic [DATA_W-1:0] lcr,
  input  logic [DATA_W-1:0] efcr,
  output bank_e             bank
);

  logic [1:0] bank_field;
  assign bank_field = efcr[2:1];

  always_comb begin
    case (bank_field)
      2'b01:   bank = BK_EXTRA1;
      2'b10:   bank = BK_EXTRA2;
      2'b11:   bank = BK_NONE;
      default: begin
        if (lcr == ENH_KEY)   bank = BK_ENHANCED;
        else if (lcr[7])      bank = BK_DIVISOR;
        else if (efcr[0])     bank = BK_SPECIAL;
        else                  bank = BK_NORMAL;
      end
    endcase
  end

endmodule

// File: rtl/uart_bank_addr_map.sv
module uart_bank_addr_map
  import uart_bank_pkg::*;
(
  input  bank_e             bank,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output reg_e              id
);

  always_comb begin
    hit = 1'b1;
    id  = RG_LCR;
    if (addr == A_LCR) begin
      id = RG_LCR;
    end else if (addr == A_EFCR) begin
      id = RG_EFCR;
    end else begin
      case (bank)
        BK_NORMAL: begin
          case (addr)
            3'd1:    id = RG_IER;
            3'd2:    id = RG_FCR;
            3'd4:    id = RG_MCR;
            3'd7:    id = RG_SCR;
            default: hit = 1'b0;
          endcase
        end
        BK_DIVISOR: begin
          case (addr)
            3'd0:    id = RG_DLL;
            3'd1:    id = RG_DLH;
            default: hit = 1'b0;
          endcase
        end
        BK_ENHANCED: begin
          case (addr)
            3'd0:    id = RG_XON_LO;
            3'd1:    id = RG_XON_HI;
            3'd2:    id = RG_EFR;
            3'd6:    id = RG_XOFF_LO;
            3'd7:    id = RG_XOFF_HI;
            default: hit = 1'b0;
          endcase
        end
        BK_SPECIAL: begin
          case (addr)
            3'd4:    id = RG_SPC0;
            3'd7:    id = RG_SPC1;
            default: hit = 1'b0;
          endcase
        end
        BK_EXTRA1: begin
          case (addr)
            3'd2:    id = RG_TXLVL;
            3'd4:    id = RG_RXLVL;
            3'd6:    id = RG_FLOWH;
            3'd7:    id = RG_FLOWL;
            default: hit = 1'b0;
          endcase
        end
        BK_EXTRA2: begin
          case (addr)
            3'd2:    id = RG_PRESC;
            3'd4:    id = RG_RS485T;
            3'd6:    id = RG_AFC2;
            3'd7:    id = RG_AFC1;
            default: hit = 1'b0;
          endcase
        end
        default: hit = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/uart_bank_regfile.sv
module uart_bank_regfile
  import uart_bank_pkg::*;
#(
  parameter int PRESC_BITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              hit,
  input  reg_e              id,
  output logic [DATA_W-1:0] q [NREG],
  output logic [DATA_W-1:0] rdata
);

  localparam logic [DATA_W-1:0] PRESC_MASK = DATA_W'((1 << PRESC_BITS) - 1);
  localparam logic [DATA_W-1:0] IER_LOW    = DATA_W'(8'h0F);

  logic ier_upper_open;
  assign ier_upper_open = q[RG_EFR][EFR_UNLOCK_BIT];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [DATA_W-1:0] FIXED_MASK =
      (i == int'(RG_PRESC)) ? PRESC_MASK : {DATA_W{1'b1}};
    logic [DATA_W-1:0] wmask;
    logic [DATA_W-1:0] r;
    logic              sel;

    assign sel = wr_en && hit && (id == reg_e'(i));

    always_comb begin
      if (i == int'(RG_IER) && !ier_upper_open) wmask = IER_LOW;
      else                                      wmask = FIXED_MASK;
    end

    always_ff @(posedge clk) begin
      if (rst)      r <= '0;
      else if (sel) r <= (r & ~wmask) | (wdata & wmask);
    end

    assign q[i] = r;
  end

  always_ff @(posedge clk) begin
    if (rst)      rdata <= '0;
    else if (hit) rdata <= q[id];
    else          rdata <= '0;
  end

endmodule

// File: rtl/uart_bank_regs.sv
module uart_bank_regs
  import uart_bank_pkg::*;
#(
  parameter logic [7:0] ENH_KEY    = 8'hBF,
  parameter int         PRESC_BITS = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  addr,
  input  logic [7:0]  wdata,
  input  logic        wr_en,
  output logic [7:0]  rdata,
  output logic [7:0]  ier,
  output logic [7:0]  fcr,
  output logic [7:0]  mcr,
  output logic [7:0]  scratch,
  output logic [7:0]  lcr,
  output logic [7:0]  efcr,
  output logic [15:0] divisor,
  output logic [7:0]  efr,
  output logic [15:0] xon,
  output logic [15:0] xoff,
  output logic [7:0]  tx_level,
  output logic [7:0]  rx_level,
  output logic [7:0]  flow_hi,
  output logic [7:0]  flow_lo,
  output logic [7:0]  prescale,
  output logic [7:0]  turnaround,
  output logic [7:0]  afc2,
  output logic [7:0]  afc1,
  output logic [7:0]  spec0,
  output logic [7:0]  spec1
);

  logic [DATA_W-1:0] regs [NREG];
  bank_e             bank;
  logic              hit;
  reg_e              id;

  uart_bank_select #(.ENH_KEY(ENH_KEY)) u_sel (
    .lcr  (regs[RG_LCR]),
    .efcr (regs[RG_EFCR]),
    .bank (bank)
  );

  uart_bank_addr_map u_map (
    .bank (bank),
    .addr (addr),
    .hit  (hit),
    .id   (id)
  );

  uart_bank_regfile #(.PRESC_BITS(PRESC_BITS)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .wdata (wdata),
    .hit   (hit),
    .id    (id),
    .q     (regs),
    .rdata (rdata)
  );

  assign ier        = regs[RG_IER];
  assign fcr        = regs[RG_FCR];
  assign mcr        = regs[RG_MCR];
  assign scratch    = regs[RG_SCR];
  assign lcr        = regs[RG_LCR];
  assign efcr       = regs[RG_EFCR];
  assign divisor    = {regs[RG_DLH], regs[RG_DLL]};
  assign efr        = regs[RG_EFR];
  assign xon        = {regs[RG_XON_HI], regs[RG_XON_LO]};
  assign xoff       = {regs[RG_XOFF_HI], regs[RG_XOFF_LO]};
  assign tx_level   = regs[RG_TXLVL];
  assign rx_level   = regs[RG_RXLVL];
  assign flow_hi    = regs[RG_FLOWH];
  assign flow_lo    = regs[RG_FLOWL];
  assign prescale   = regs[RG_PRESC];
  assign turnaround = regs[RG_RS485T];
  assign afc2       = regs[RG_AFC2];
  assign afc1       = regs[RG_AFC1];
  assign spec0      = regs[RG_SPC0];
  assign spec1      = regs[RG_SPC1];

endmodule

// File: rtl/uart_bank_regs_chk.sv
module uart_bank_regs_chk #(
  parameter logic [7:0] ENH_KEY    = 8'hBF,
  parameter int         PRESC_BITS = 4
) (
  input logic        clk,
  input logic        rst,
  input logic [2:0]  addr,
  input logic [7:0]  wdata,
  input logic        wr_en,
  input logic [7:0]  rdata,
  input logic [7:0]  ier,
  input logic [7:0]  lcr,
  input logic [7:0]  efcr,
  input logic [7:0]  efr,
  input logic [15:0] xon,
  input logic [15:0] xoff,
  input logic [7:0]  prescale
);

  localparam logic [7:0] PMASK = 8'((1 << PRESC_BITS) - 1);

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (lcr == 8'h00 && efcr == 8'h00 && ier == 8'h00 && rdata == 8'h00)); // R1

  AST_LCR_ALWAYS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 3'd3) |=> (lcr == $past(wdata))); // R3

  AST_EFCR_ALWAYS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 3'd5) |=> (efcr == $past(wdata))); // R3

  AST_ENH_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (lcr != ENH_KEY || efcr[2:1] != 2'b00) |=> ($stable(xon) && $stable(xoff) && $stable(efr))); // R5

  AST_PRESC_LOW_ONLY: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 3'd2 && efcr[2:1] == 2'b10) |=> (prescale == ($past(wdata) & PMASK))); // R8

  AST_IER_UPPER_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !efr[4]) |=> (ier[7:4] == $past(ier[7:4]))); // R9

  AST_NONE_BANK_QUIET: assert property (@(posedge clk) disable iff (rst)
    (efcr[2:1] == 2'b11 && addr != 3'd3 && addr != 3'd5) |=> (rdata == 8'h00)); // R11

  AST_NORMAL_HOLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (efcr == 8'h00 && !lcr[7] && (addr == 3'd0 || addr == 3'd6)) |=> (rdata == 8'h00)); // R11

endmodule

bind uart_bank_regs uart_bank_regs_chk #(.ENH_KEY(ENH_KEY), .PRESC_BITS(PRESC_BITS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .addr     (addr),
  .wdata    (wdata),
  .wr_en    (wr_en),
  .rdata    (rdata),
  .ier      (ier),
  .lcr      (lcr),
  .efcr     (efcr),
  .efr      (efr),
  .xon      (xon),
  .xoff     (xoff),
  .prescale (prescale)
);

// File: tb/uart_bank_regs_test.sv
`timescale 1ns/1ps
module uart_bank_regs_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  rdata, ier, fcr, mcr, scratch, lcr, efcr, efr;
  logic [15:0] divisor, xon, xoff;
  logic [7:0]  tx_level, rx_level, flow_hi, flow_lo, prescale, turnaround;
  logic [7:0]  afc2, afc1, spec0, spec1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  uart_bank_regs uut (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rdata(rdata), .ier(ier), .fcr(fcr), .mcr(mcr), .scratch(scratch),
    .lcr(lcr), .efcr(efcr), .divisor(divisor), .efr(efr), .xon(xon),
    .xoff(xoff), .tx_level(tx_level), .rx_level(rx_level),
    .flow_hi(flow_hi), .flow_lo(flow_lo), .prescale(prescale),
    .turnaround(turnaround), .afc2(afc2), .afc1(afc1),
    .spec0(spec0), .spec1(spec1)
  );

  // vector: {req[3:0], check, write, addr[2:0], data[7:0], expected[7:0]}
  function automatic logic [24:0] vw(int req, int a, int d);
    return {4'(req), 1'b0, 1'b1, 3'(a), 8'(d), 8'h00};
  endfunction
  function automatic logic [24:0] vr(int req, int a, int e);
    return {4'(req), 1'b1, 1'b0, 3'(a), 8'h00, 8'(e)};
  endfunction

  localparam int NV = 60;
  localparam logic [24:0] VEC [NV] = '{
    vw(9, 1, 'h5A), vr(9, 1, 'h0A),                     // R9 upper IER locked
    vw(2, 2, 'h81), vr(2, 2, 'h81),                     // R2 FIFO control
    vw(2, 4, 'h13), vw(2, 7, 'hC3),                     // R2 modem, scratch
    vr(2, 4, 'h13), vr(2, 7, 'hC3),
    vr(11, 0, 'h00), vr(11, 6, 'h00),                   // R11 holes
    vw(3, 3, 'h83),                                     // R3 open divisor
    vw(4, 0, 'h34), vw(4, 1, 'h12),                     // R4
    vr(4, 0, 'h34), vr(4, 1, 'h12), vr(4, 7, 'h00),
    vr(3, 3, 'h83),
    vw(3, 3, 'hBF),                                     // R5 enhanced key
    vw(5, 2, 'h10), vw(5, 0, 'h11), vw(5, 1, 'h13),
    vw(5, 6, 'h19), vw(5, 7, 'h1B),
    vr(5, 2, 'h10), vr(5, 0, 'h11), vr(5, 7, 'h1B), vr(5, 4, 'h00),
    vw(3, 3, 'h03),
    vw(9, 1, 'hF5), vr(9, 1, 'hF5),                     // R9 unlocked
    vw(3, 5, 'h02),                                     // R6 bank field 01
    vw(6, 2, 'h40), vw(6, 4, 'h41), vw(6, 6, 'h42), vw(6, 7, 'h43),
    vr(6, 2, 'h40), vr(6, 7, 'h43),
    vr(11, 1, 'h00),
    vw(3, 5, 'h04),                                     // R7 bank field 10
    vw(8, 2, 'hA7), vr(8, 2, 'h07),                     // R8 prescaler
    vw(7, 4, 'h55), vw(7, 6, 'h66), vw(7, 7, 'h77),
    vr(7, 6, 'h66), vr(3, 5, 'h04),
    vw(3, 5, 'h06),                                     // R11 bank field 11
    vw(11, 2, 'hEE), vr(11, 2, 'h00), vr(3, 5, 'h06),
    vw(3, 5, 'h01),                                     // R10 special
    vw(10, 4, 'h21), vw(10, 7, 'h22),
    vr(10, 4, 'h21), vr(10, 1, 'h00), vr(3, 3, 'h03),
    vw(3, 5, 'h00),
    vr(10, 1, 'hF5), vr(10, 4, 'h13), vr(2, 7, 'hC3)
  };

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycle(logic w, logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = w; addr = a; wdata = d;
    @(posedge clk);
    #1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #100000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    check("R1 rdata", 16'(rdata), 16'h0000);
    check("R1 ier", 16'(ier), 16'h0000);
    check("R1 lcr", 16'(lcr), 16'h0000);
    check("R1 efcr", 16'(efcr), 16'h0000);
    check("R1 divisor", divisor, 16'h0000);
    check("R1 xon", xon, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      logic [24:0] v;
      v = VEC[i];
      @(negedge clk);
      wr_en = v[19]; addr = v[18:16]; wdata = v[15:8];
      @(posedge clk);
      #1;
      if (v[20])
        check($sformatf("R%0d vector %0d", v[24:21], i), 16'(rdata), 16'(v[7:0]));
    end
    @(negedge clk);
    wr_en = 1'b0;

    // R11 bank-field-11 write left other registers untouched; R6..R10 ports
    check("R11 tx_level kept", 16'(tx_level), 16'h0040);
    check("R11 prescale kept", 16'(prescale), 16'h0007);
    check("R4 divisor port", divisor, 16'h1234);
    check("R5 xon port", xon, 16'h1311);
    check("R5 xoff port", xoff, 16'h1B19);
    check("R5 efr port", 16'(efr), 16'h0010);
    check("R6 levels", {rx_level, flow_hi}, 16'h4142);
    check("R6 flow_lo", 16'(flow_lo), 16'h0043);
    check("R7 turnaround", 16'(turnaround), 16'h0055);
    check("R7 afc", {afc2, afc1}, 16'h6677);
    check("R10 spec", {spec0, spec1}, 16'h2122);
    check("R2 fcr mcr", {fcr, mcr}, 16'h8113);

    // R12 write and read of scratch in one cycle: old value returned
    @(negedge clk);
    wr_en = 1'b1; addr = 3'd7; wdata = 8'h99;
    @(posedge clk); #1;
    check("R12 same-cycle read", 16'(rdata), 16'h00C3);
    @(negedge clk);
    wr_en = 1'b0; addr = 3'd7;
    @(posedge clk); #1;
    check("R12 read after write", 16'(rdata), 16'h0099);

    // R12 bank change while reading line control
    @(negedge clk);
    wr_en = 1'b1; addr = 3'd3; wdata = 8'h80;
    @(posedge clk); #1;
    check("R12 lcr old value", 16'(rdata), 16'h0003);
    @(negedge clk);
    wr_en = 1'b0; addr = 3'd0;
    @(posedge clk); #1;
    check("R12 new bank divisor low", 16'(rdata), 16'h0034);
    check("R2 scratch port", 16'(scratch), 16'h0099);

    // R1 reset again clears everything
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 rdata after reset", 16'(rdata), 16'h0000);
    check("R1 spec after reset", {spec0, spec1}, 16'h0000);
    check("R1 prescale after reset", 16'(prescale), 16'h0000);
    check("R1 efr after reset", 16'(efr), 16'h0000);
    cycle(1'b0, 3'd1, 8'h00);
    check("R1 ier read after reset", 16'(rdata), 16'h0000);

    finish_run();
  end

endmodule